// File: doc/BRIEF.md
# Masked Word-Slice Memory Access Controller

This block decodes a 12-bit control word and carries out one access to a 256-entry array. Each entry is 64 bits wide and has its own validity flag. A 32-bit bidirectional bus reaches one half of an entry at a time. A half-select pin chooses which half. Two kinds of access are supported. The first uses an internal address register, which moves forward or backward by one after each access. The second uses the address of the highest-priority match, which a separate comparison stage supplies together with a match flag.

A write can be masked through a bank of seven mask words held outside the block. The mask select field picks one of these words, and the value zero means no mask. A read returns the selected half and the stored validity level one clock after the command is accepted. The block drives the bus only during that one cycle.

Top module: `slice_mem_ctrl`

## Requirements
- R1: With `cmdEn` high, only the low-six-bit codes 6'b100110, 6'b100111 and 6'b000010 perform an access. Every other code changes neither the array nor the address register. Bits 11..9 of the control word are never examined.
- R2: Code 6'b100110 accesses the entry at the address register and then adds one to the register, wrapping from 255 to 0. The register is 0 after reset.
- R3: Code 6'b100111 accesses the entry at the address register and then subtracts one from the register, wrapping from 0 to 255.
- R4: `halfSel` low maps bus bits 31..0 onto entry bits 31..0, and `halfSel` high maps them onto entry bits 63..32. The other half of the entry is left untouched.
- R5: The mask select field is control-word bits 8..6. A value of 0 writes the whole half. A value k from 1 to 7 uses mask word k, which is `maskBank` bits k*64-1 down to (k-1)*64, sliced by `halfSel` in the same way as the entry. Only bits whose mask bit is 0 are updated. On reads the field is ignored.
- R6: A write sets the entry's validity flag from the level on `vbN`, where low means valid and high means empty. A read drives `vbN` with that stored level. After reset every entry reads as empty.
- R7: Code 6'b000010 with `hpmValid` high reads or writes the entry at `hpmAddr` and leaves the address register unchanged.
- R8: Code 6'b000010 with `hpmValid` low drives neither `dataBus` nor `vbN` on a read, and on a write it leaves the array unchanged.
- R9: Read data and validity appear on the pins in the cycle after the command edge. At all other times, including after reset, both pins are high impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdEn | input | 1 | Control word is present this cycle |
| cmdWord | input | 12 | Control word: bits 8..6 select the mask, bits 5..0 are the operation |
| wrN | input | 1 | Low for a write, high for a read |
| halfSel | input | 1 | Selects the entry half: low for 31..0, high for 63..32 |
| dataBus | inout | 32 | Write data in, read data out |
| vbN | inout | 1 | Validity level: an input on writes, driven on reads (low means valid) |
| hpmAddr | input | 8 | Address of the highest-priority match |
| hpmValid | input | 1 | The last comparison found a match |
| maskBank | input | 448 | Mask words 1 to 7, 64 bits each |

## Verification
The assertions take for granted that, whenever a write is issued, the bus and the validity pin carry known values driven from outside. They also assume that `hpmAddr` and `hpmValid` are stable while a command is present. The stimulus drives both pins only during write cycles and releases them before the read cycle. It changes all inputs only on falling edges. The mask bank and the match inputs are held constant across each command. Floating outputs are detected by driving a known pattern from the bench and reading back exactly that pattern.

// File: rtl/smc_pkg.sv
package smcPkg;
  parameter int unsigned ADDR_W = 8;
  parameter int unsigned HALF_W = 32;
  parameter int unsigned SEL_W  = 3;
  localparam int unsigned DEPTH   = 1 << ADDR_W;
  localparam int unsigned ENTRY_W = 2 * HALF_W;
  localparam int unsigned NUM_MASK = 1 << SEL_W;

  typedef enum logic [5:0] {
    OP_AR_INC = 6'b100110,
    OP_AR_DEC = 6'b100111,
    OP_HPM    = 6'b000010
  } opCodeT;

  typedef struct packed {
    logic              wrEn;
    logic              rdEn;
    logic [ADDR_W-1:0] addr;
    logic [SEL_W-1:0]  maskSel;
    logic              hiHalf;
  } accessReqT;
endpackage

// File: rtl/smc_ctrl.sv
module smc_ctrl
  import smcPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdEn,
  input  logic [11:0]       cmdWord,
  input  logic              wrN,
  input  logic              halfSel,
  input  logic [ADDR_W-1:0] hpmAddr,
  input  logic              hpmValid,
  output accessReqT         req
);
  logic [5:0]        opCode;
  logic              isInc, isDec, isHpm, known, hit;
  logic [ADDR_W-1:0] arQ;

  assign opCode = cmdWord[5:0];
  assign isInc  = (opCode == OP_AR_INC);
  assign isDec  = (opCode == OP_AR_DEC);
  assign isHpm  = (opCode == OP_HPM);
  assign known  = isInc | isDec | isHpm;
  assign hit    = isHpm ? hpmValid : 1'b1;

  always_comb begin
    req.wrEn    = cmdEn & known & hit & ~wrN;
    req.rdEn    = cmdEn & known & hit & wrN;
    req.addr    = isHpm ? hpmAddr : arQ;
    req.maskSel = cmdWord[8:6];
    req.hiHalf  = halfSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      arQ <= '0;
    end else if (cmdEn && isInc) begin
      arQ <= arQ + 1'b1;
    end else if (cmdEn && isDec) begin
      arQ <= arQ - 1'b1;
    end
  end

  // R2
  ar_inc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdEn && cmdWord[5:0] == 6'b100110) |=> (arQ == ADDR_W'($past(arQ) + 1)));
  // R3
  ar_dec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdEn && cmdWord[5:0] == 6'b100111) |=> (arQ == ADDR_W'($past(arQ) - 1)));
  // R7
  ar_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdEn || cmdWord[5:0] == 6'b000010) |=> $stable(arQ));
endmodule

// File: rtl/smc_datapath.sv
module smc_datapath
  import smcPkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  accessReqT                        req,
  input  logic [HALF_W-1:0]                busIn,
  input  logic                             vbIn,
  input  logic [(NUM_MASK-1)*ENTRY_W-1:0]  maskBank,
  output logic [HALF_W-1:0]                rdData,
  output logic                             rdEmpty,
  output logic                             rdOe
);
  logic [ENTRY_W-1:0] memQ [DEPTH];
  logic [DEPTH-1:0]   emptyQ;
  logic [ENTRY_W-1:0] maskTab [NUM_MASK];
  logic [ENTRY_W-1:0] entry, maskWord;
  logic [HALF_W-1:0]  oldSlice, maskSlice, newSlice;

  assign maskTab[0] = '0;
  for (genvar k = 1; k < NUM_MASK; k++) begin : g_mask
    assign maskTab[k] = maskBank[(k-1)*ENTRY_W +: ENTRY_W];
  end

  always_comb begin
    entry     = memQ[req.addr];
    maskWord  = maskTab[req.maskSel];
    oldSlice  = req.hiHalf ? entry[ENTRY_W-1:HALF_W] : entry[HALF_W-1:0];
    maskSlice = req.hiHalf ? maskWord[ENTRY_W-1:HALF_W] : maskWord[HALF_W-1:0];
    newSlice  = (oldSlice & maskSlice) | (busIn & ~maskSlice);
  end

  always_ff @(posedge clk) begin
    if (req.wrEn) begin
      if (req.hiHalf) memQ[req.addr][ENTRY_W-1:HALF_W] <= newSlice;
      else            memQ[req.addr][HALF_W-1:0]       <= newSlice;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      emptyQ  <= '1;
      rdOe    <= 1'b0;
      rdData  <= '0;
      rdEmpty <= 1'b1;
    end else begin
      rdOe <= req.rdEn;
      if (req.wrEn) emptyQ[req.addr] <= vbIn;
      if (req.rdEn) begin
        rdData  <= oldSlice;
        rdEmpty <= emptyQ[req.addr];
      end
    end
  end

  // R9
  oe_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdOe |-> $past(req.rdEn));
  // R5
  unmasked_lo_chk: assert property (@(posedge clk) disable iff (!rstN)
    (req.wrEn && req.maskSel == '0 && !req.hiHalf)
      |=> (memQ[$past(req.addr)][HALF_W-1:0] == $past(busIn)));
  // R6
  vb_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    req.wrEn |=> (emptyQ[$past(req.addr)] == $past(vbIn)));
endmodule

// File: rtl/slice_mem_ctrl.sv
module slice_mem_ctrl
  import smcPkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            cmdEn,
  input  logic [11:0]                     cmdWord,
  input  logic                            wrN,
  input  logic                            halfSel,
  inout  wire  [HALF_W-1:0]               dataBus,
  inout  wire                             vbN,
  input  logic [ADDR_W-1:0]               hpmAddr,
  input  logic                            hpmValid,
  input  logic [(NUM_MASK-1)*ENTRY_W-1:0] maskBank
);
  accessReqT         req;
  logic [HALF_W-1:0] rdData;
  logic              rdEmpty, rdOe;

  smc_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .cmdEn(cmdEn), .cmdWord(cmdWord), .wrN(wrN),
    .halfSel(halfSel), .hpmAddr(hpmAddr), .hpmValid(hpmValid), .req(req)
  );

  smc_datapath dp_i (
    .clk(clk), .rstN(rstN), .req(req), .busIn(dataBus), .vbIn(vbN),
    .maskBank(maskBank), .rdData(rdData), .rdEmpty(rdEmpty), .rdOe(rdOe)
  );

  assign dataBus = rdOe ? rdData : {HALF_W{1'bz}};
  assign vbN     = rdOe ? rdEmpty : 1'bz;
endmodule

// File: tb/slice_mem_ctrl_tb.sv
`timescale 1ns/1ps
module slice_mem_ctrl_tb_top;
  localparam logic [5:0] INC = 6'b100110, DEC = 6'b100111, HPM = 6'b000010;
  localparam logic [31:0] PAT = 32'hA5C3_5A3C;

  logic clk = 0, rstN = 0, cmdEn = 0, wrN = 1, halfSel = 0, hpmValid = 0;
  logic [11:0] cmdWord = '0;
  logic [7:0] hpmAddr = '0;
  logic [447:0] maskBank;
  logic [31:0] drvData = '0;
  logic drvEn = 0, vbDrv = 0, vbDrvEn = 0;
  wire [31:0] dataBus;
  wire vbN;
  int vectors = 0, fails = 0, arM = 0;
  logic [63:0] refMem [256];
  logic refEmpty [256];

  assign dataBus = drvEn ? drvData : 32'hzzzz_zzzz;
  assign vbN = vbDrvEn ? vbDrv : 1'bz;
  always #2.5 clk = ~clk;

  slice_mem_ctrl dut_i (.clk(clk), .rstN(rstN), .cmdEn(cmdEn), .cmdWord(cmdWord), .wrN(wrN),
    .halfSel(halfSel), .dataBus(dataBus), .vbN(vbN), .hpmAddr(hpmAddr), .hpmValid(hpmValid),
    .maskBank(maskBank));

  function automatic logic [63:0] maskOf(int k);
    if (k == 0) return 64'h0;
    return {8{8'((k * 37 + 11) & 8'hFF)}};
  endfunction

  function automatic logic [31:0] patA(int a, int h);
    return {8'(a), ~8'(a), (h != 0) ? 8'h5C : 8'h3A, 8'(a) ^ 8'h77};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic modelWrite(int a, logic hi, int k, logic [31:0] d, logic vb);
    logic [63:0] m = maskOf(k);
    logic [31:0] ms = hi ? m[63:32] : m[31:0];
    logic [31:0] old = hi ? refMem[a][63:32] : refMem[a][31:0];
    logic [31:0] nw = (old & ms) | (d & ~ms);
    if (hi) refMem[a][63:32] = nw; else refMem[a][31:0] = nw;
    refEmpty[a] = vb;
  endtask

  // Applies one command; returns in the following cycle, before the next edge.
  task automatic issue(logic [11:0] cw, logic w, logic hi, logic [31:0] d, logic vb);
    @(negedge clk);
    cmdWord = cw; cmdEn = 1; wrN = w; halfSel = hi;
    drvEn = !w; drvData = d; vbDrvEn = !w; vbDrv = vb;
    @(negedge clk);
    cmdEn = 0; drvEn = 0; vbDrvEn = 0;
    #0.5;
  endtask

  task automatic checkFloat(string req);
    for (int v = 0; v < 2; v++) begin
      drvEn = 1; drvData = PAT ^ {32{v[0]}}; vbDrvEn = 1; vbDrv = v[0];
      #0.3;
      check(req, dataBus, PAT ^ {32{v[0]}});
      check(req, {31'b0, vbN}, {31'b0, v[0]});
    end
    drvEn = 0; vbDrvEn = 0;
  endtask

  task automatic readAndCheck(string req, logic [11:0] cw, logic hi, int a);
    issue(cw, 1'b1, hi, 32'h0, 1'b0);
    check(req, dataBus, hi ? refMem[a][63:32] : refMem[a][31:0]);
    check(req, {31'b0, vbN}, {31'b0, refEmpty[a]});
  endtask

  initial begin
    for (int k = 1; k < 8; k++) maskBank[(k-1)*64 +: 64] = maskOf(k);
    for (int a = 0; a < 256; a++) refEmpty[a] = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1;
    #0.5;
    checkFloat("R9 reset");
    // R2 R4 R6: unmasked fill of both halves with post-increment
    for (int h = 0; h < 2; h++)
      for (int i = 0; i < 256; i++) begin
        issue({3'(i), 3'b000, INC}, 1'b0, h[0], patA(arM, h), i[0] ^ h[0]);
        modelWrite(arM, h[0], 0, patA(arM, h), i[0] ^ h[0]);
        arM = (arM + 1) % 256;
      end
    // R5 read ignores the mask field; R2 wrap back to entry 0
    for (int h = 0; h < 2; h++)
      for (int i = 0; i < 256; i++) begin
        readAndCheck("R2/R4/R5/R6 fill readback", {3'(i + 3), 3'(i), INC}, h[0], arM);
        arM = (arM + 1) % 256;
      end
    // R3 R5: masked writes with post-decrement across the 0 -> 255 wrap
    for (int i = 0; i < 64; i++) begin
      logic [31:0] d = 32'h9E37_79B9 * (i + 1);
      issue({3'(i), 3'(i % 8), DEC}, 1'b0, i[0], d, i[1]);
      modelWrite(arM, i[0], i % 8, d, i[1]);
      arM = (arM + 255) % 256;
    end
    for (int h = 0; h < 2; h++)
      for (int i = 0; i < 256; i++) begin
        readAndCheck("R3/R5 masked readback", {3'b0, 3'b0, INC}, h[0], arM);
        arM = (arM + 1) % 256;
      end
    // R1: unknown codes change nothing
    for (int c = 0; c < 64; c++) begin
      if (c == 6'b100110 || c == 6'b100111 || c == 6'b000010) continue;
      issue({3'b111, 3'b000, 6'(c)}, 1'b0, c[0], 32'hDEAD_0000 | c, 1'b0);
      checkFloat("R1 unknown code no drive");
    end
    readAndCheck("R1 array and address unchanged", {6'b0, INC}, 1'b0, arM);
    arM = (arM + 1) % 256;
    readAndCheck("R1 array upper unchanged", {6'b0, DEC}, 1'b1, arM);
    arM = (arM + 255) % 256;
    // R7: match-location access, address register untouched
    hpmValid = 1; hpmAddr = 8'h5A;
    issue({3'b010, 3'd3, HPM}, 1'b0, 1'b1, 32'h1234_5678, 1'b0);
    modelWrite(8'h5A, 1'b1, 3, 32'h1234_5678, 1'b0);
    issue({3'b000, 3'd0, HPM}, 1'b0, 1'b0, 32'hCAFE_F00D, 1'b1);
    modelWrite(8'h5A, 1'b0, 0, 32'hCAFE_F00D, 1'b1);
    readAndCheck("R7 match read upper", {3'b0, 3'd5, HPM}, 1'b1, 8'h5A);
    readAndCheck("R7 match read lower", {3'b0, 3'd0, HPM}, 1'b0, 8'h5A);
    readAndCheck("R7 address register held", {6'b0, INC}, 1'b0, arM);
    arM = (arM + 1) % 256;
    // R8: no match: write ignored, read floats
    hpmValid = 0;
    issue({3'b0, 3'd0, HPM}, 1'b0, 1'b0, 32'h0BAD_0BAD, 1'b0);
    issue({3'b0, 3'd0, HPM}, 1'b1, 1'b0, 32'h0, 1'b0);
    checkFloat("R8 miss read floats");
    hpmValid = 1;
    readAndCheck("R8 miss write ignored", {3'b0, 3'd0, HPM}, 1'b0, 8'h5A);
    // R9: drive lasts one cycle only
    @(negedge clk); #0.5;
    checkFloat("R9 released after read");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #900000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule